// File: doc/BRIEF.md
# Immediate Prefix Extender

This block widens the short immediate fields of a compact RISC instruction set. Its main part is a small prefix register that sits next to the decoder. A prefix instruction loads a 17-bit field from the instruction word into the register, sign-extended to 20 bits. The next instruction that takes an extended immediate places the stored 20 bits above its own 12-bit immediate, which forms a 32-bit operand. The register then returns to zero on its own.

When no prefix came first, the register already holds zero. The operand is then the 12-bit immediate with zero upper bits, so software never has to clear the register before a plain short immediate. All other instructions leave the register as it is. The decoder supplies one strobe per instruction class. A synchronous clear input lets the pipeline drop a pending prefix, for example when an interrupt is taken. Reset is asynchronous and active-low. The block synchronises its release internally.

Top module: `imm_prefix_ext`

## Requirements
- R1: While reset is low, and after it is released, the upper 20 operand bits are zero. Strobes applied while reset is low have no effect.
- R2: A cycle with `pfx_strb` high and `kx_clr` low stores instruction bits [28:12], sign-extended from bit 28 to 20 bits. From the next cycle on, the stored value appears on `opnd[31:12]`.
- R3: `opnd[11:0]` always equals `instr[11:0]`, in the same cycle and without a register in the path.
- R4: A cycle with `imm_strb` high and both `pfx_strb` and `kx_clr` low sets the stored value to zero from the next cycle on. That cycle's own operand still carries the old stored value.
- R5: A cycle with all three strobes low keeps the stored value unchanged.
- R6: A prefix that arrives while a value is already stored replaces that value.
- R7: `kx_clr` high zeroes the stored value at the next edge. It takes priority over both other strobes.
- R8: When `pfx_strb` and `imm_strb` are both high, the operand of that cycle uses the old stored value and the prefix is loaded.
- R9: With nothing stored, the operand equals `instr[11:0]` with zero upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| kx_clr | input | 1 | Synchronous clear of the stored prefix |
| pfx_strb | input | 1 | Decoded prefix instruction |
| imm_strb | input | 1 | Decoded instruction that consumes an extended immediate |
| instr | input | 29 | Instruction bits [28:0]; [28:12] prefix field, [11:0] immediate |
| opnd | output | 32 | Extended operand {stored[19:0], instr[11:0]} |

## Verification
The operand is tried with the following input patterns:
- **Positive and negative prefix fields.** These separate correct sign extension of bit 28 from zero fill.
- **Prefix–consume–consume runs.** These show whether the value is cleared after its first use.
- **Runs of idle cycles between prefix and use.** These show whether the value is kept.
- **Back-to-back prefixes.** These check that a new prefix overwrites the old one.
- **Clear and simultaneous strobes.** Clear combined with the other strobes, and prefix together with consume, fix the priority order.
- **Random strobe and instruction mixes.** These are checked against a reference model of the register. They catch orderings the directed cases miss.
- **Reset.** Asserting reset in the middle of a run tests the asynchronous clear of the register.

// File: rtl/ipx_pkg.sv
package ipx_pkg;
  typedef enum logic [1:0] {
    IPX_HOLD    = 2'd0,
    IPX_CLEAR   = 2'd1,
    IPX_LOAD    = 2'd2,
    IPX_CONSUME = 2'd3
  } ipx_op_e;
endpackage

// File: rtl/ipx_rst_sync.sv
module ipx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/ipx_field.sv
module ipx_field #(
  parameter int FW = 17,
  parameter int OW = 20
) (
  input  logic [FW-1:0] fld,
  output logic [OW-1:0] ext
);
  generate
    if (OW > FW) begin : g_sext
      assign ext = {{(OW-FW){fld[FW-1]}}, fld};
    end else begin : g_trunc
      assign ext = fld[OW-1:0];
    end
  endgenerate
endmodule

// File: rtl/ipx_ctrl.sv
module ipx_ctrl
  import ipx_pkg::*;
#(
  parameter int HI_W = 20
) (
  input  logic            clr,
  input  logic            pfx,
  input  logic            cns,
  input  logic [HI_W-1:0] ext,
  output logic            en,
  output logic [HI_W-1:0] d
);
  ipx_op_e op;

  // clear outranks prefix, prefix outranks consume
  always_comb begin
    if (clr)      op = IPX_CLEAR;
    else if (pfx) op = IPX_LOAD;
    else if (cns) op = IPX_CONSUME;
    else          op = IPX_HOLD;
  end

  always_comb begin
    en = 1'b1;
    d  = '0;
    unique case (op)
      IPX_HOLD: en = 1'b0;
      IPX_LOAD: d  = ext;
      default:  d  = '0;
    endcase
  end
endmodule

// File: rtl/ipx_hold_reg.sv
module ipx_hold_reg #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/imm_prefix_ext.sv
module imm_prefix_ext #(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 12,
  parameter int PFX_W   = 17,
  parameter int SYNC_ST = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    kx_clr,
  input  logic                    pfx_strb,
  input  logic                    imm_strb,
  input  logic [IMM_W+PFX_W-1:0]  instr,
  output logic [DATA_W-1:0]       opnd
);
  localparam int HI_W   = DATA_W - IMM_W;
  localparam int PFX_LO = IMM_W;
  localparam int PFX_HI = IMM_W + PFX_W - 1;

  logic            rst_q_n;
  logic [HI_W-1:0] pfx_ext;
  logic [HI_W-1:0] hi_d;
  logic [HI_W-1:0] hi_q;
  logic            hi_en;

  ipx_rst_sync #(.STAGES(SYNC_ST)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  ipx_field #(.FW(PFX_W), .OW(HI_W)) u_field (
    .fld (instr[PFX_HI:PFX_LO]),
    .ext (pfx_ext)
  );

  ipx_ctrl #(.HI_W(HI_W)) u_ctrl (
    .clr (kx_clr),
    .pfx (pfx_strb),
    .cns (imm_strb),
    .ext (pfx_ext),
    .en  (hi_en),
    .d   (hi_d)
  );

  ipx_hold_reg #(.W(HI_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_q_n),
    .en    (hi_en),
    .d     (hi_d),
    .q     (hi_q)
  );

  assign opnd = {hi_q, instr[IMM_W-1:0]};
endmodule

// File: rtl/imm_prefix_ext_chk.sv
module imm_prefix_ext_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12,
  parameter int PFX_W  = 17
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   kx_clr,
  input logic                   pfx_strb,
  input logic                   imm_strb,
  input logic [IMM_W+PFX_W-1:0] instr,
  input logic [DATA_W-1:0]      opnd
);
  localparam int HI_W = DATA_W - IMM_W;

  logic [HI_W-1:0] exp_ext;
  logic [HI_W-1:0] opnd_hi;

  always_comb begin
    for (int i = 0; i < HI_W; i++)
      exp_ext[i] = (i < PFX_W) ? instr[IMM_W+i] : instr[IMM_W+PFX_W-1];
  end

  assign opnd_hi = opnd[DATA_W-1:IMM_W];

  // R3
  low_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opnd[IMM_W-1:0] == instr[IMM_W-1:0]);

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pfx_strb && !kx_clr) |=> opnd_hi == $past(exp_ext));

  // R4
  consume_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_strb && !pfx_strb && !kx_clr) |=> opnd_hi == '0);

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!imm_strb && !pfx_strb && !kx_clr) |=> opnd_hi == $past(opnd_hi));

  // R7
  sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kx_clr |=> opnd_hi == '0);
endmodule

bind imm_prefix_ext imm_prefix_ext_chk #(
  .DATA_W (DATA_W),
  .IMM_W  (IMM_W),
  .PFX_W  (PFX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .kx_clr   (kx_clr),
  .pfx_strb (pfx_strb),
  .imm_strb (imm_strb),
  .instr    (instr),
  .opnd     (opnd)
);

// File: tb/imm_prefix_ext_test.sv
`timescale 1ns/1ps
module imm_prefix_ext_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        kx_clr;
  logic        pfx_strb;
  logic        imm_strb;
  logic [28:0] instr;
  logic [31:0] opnd;

  int          n_chk = 0;
  int          n_err = 0;
  logic [19:0] k_model = '0;

  imm_prefix_ext uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .kx_clr   (kx_clr),
    .pfx_strb (pfx_strb),
    .imm_strb (imm_strb),
    .instr    (instr),
    .opnd     (opnd)
  );

  always #4 clk = ~clk;

  function automatic logic [19:0] sx(input logic [28:0] w);
    return {{3{w[28]}}, w[28:12]};
  endfunction

  function automatic logic [28:0] mk(input logic [16:0] f, input logic [11:0] i);
    return {f, i};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: opnd=%08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic step(input logic p, input logic u, input logic c,
                      input logic [28:0] w, input string tag);
    @(negedge clk);
    pfx_strb = p; imm_strb = u; kx_clr = c; instr = w;
    #1;
    check(tag, opnd, {k_model, w[11:0]});
    if (c)      k_model = '0;
    else if (p) k_model = sx(w);
    else if (u) k_model = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pfx_strb = 0; imm_strb = 0; kx_clr = 0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    string tag;
    int r;
    logic p, u, c;
    logic [28:0] w;
    void'($urandom(32'h1F2E3D4C));
    rst_n = 0; kx_clr = 0; imm_strb = 0; instr = '0;
    // R1: prefix strobe during reset must be ignored
    pfx_strb = 1; instr = mk(17'h1ABCD, 12'h321);
    repeat (3) @(negedge clk);
    #1 check("R1", opnd, {20'h0, 12'h321});
    rst_n = 1;
    pfx_strb = 0;
    idle(3);
    step(0, 1, 0, mk(17'h1FFFF, 12'hABC), "R1");
    // R9: nothing stored
    step(0, 1, 0, mk(17'h00000, 12'hFFF), "R9");
    // R2: positive field
    step(1, 0, 0, mk(17'h01234, 12'h000), "R9");
    step(0, 1, 0, mk(17'h1FFFF, 12'h5A5), "R2");
    step(0, 1, 0, mk(17'h0AAAA, 12'h111), "R4");
    // R2 negative field, R5 hold across idle cycles
    step(1, 0, 0, mk(17'h18001, 12'h222), "R4");
    step(0, 0, 0, mk(17'h00F0F, 12'h333), "R5");
    step(0, 0, 0, mk(17'h0FFFF, 12'h444), "R5");
    step(0, 1, 0, mk(17'h00000, 12'h7E7), "R2");
    step(0, 0, 0, mk(17'h12345, 12'h000), "R4");
    // R6 overwrite
    step(1, 0, 0, mk(17'h0AAAA, 12'h001), "R4");
    step(1, 0, 0, mk(17'h15555, 12'h002), "R6");
    step(0, 1, 0, mk(17'h00000, 12'h003), "R6");
    // R7 clear, with priority over prefix
    step(1, 0, 0, mk(17'h0F00F, 12'h004), "R4");
    step(0, 1, 1, mk(17'h00000, 12'h005), "R7");
    step(0, 1, 0, mk(17'h00000, 12'h006), "R7");
    step(1, 0, 1, mk(17'h1FFFF, 12'h007), "R7");
    step(0, 1, 0, mk(17'h00000, 12'h008), "R7");
    // R8 prefix and consume together
    step(1, 0, 0, mk(17'h00777, 12'h009), "R7");
    step(1, 1, 0, mk(17'h1C000, 12'h00A), "R8");
    step(0, 1, 0, mk(17'h00000, 12'hC3C), "R8");
    // R3 low bits follow combinationally
    step(0, 0, 0, mk(17'h00000, 12'h9F1), "R3");
    // R1 asynchronous reset mid-run
    step(1, 0, 0, mk(17'h13579, 12'h000), "R3");
    @(negedge clk);
    pfx_strb = 0; rst_n = 0;
    #1 check("R1", opnd[31:12], 20'h0);
    k_model = '0;
    @(negedge clk) rst_n = 1;
    idle(3);
    step(0, 1, 0, mk(17'h00000, 12'h0F0), "R1");
    // random mix against the model
    tag = "R9";
    for (int i = 0; i < 400; i++) begin
      r = $urandom_range(0, 9);
      p = (r <= 2) || (r == 7);
      u = (r >= 3 && r <= 5) || (r == 7);
      c = (r == 6);
      w = 29'($urandom);
      step(p, u, c, w, tag);
      if (c)          tag = "R7";
      else if (p & u) tag = "R8";
      else if (p)     tag = "R2";
      else if (u)     tag = "R4";
      else            tag = "R5";
    end
    idle(1);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule